// File: doc/BRIEF.md
# Delayed Pre-Trigger Scheduler

This block turns one start event into a timed set of single-cycle pre-trigger pulses for an ADC, plus one interrupt flag. The start event is either a rising edge on `trig_in` or a software write, chosen by a control bit. After the event a counter runs from zero up to a programmable modulus. It then stops, or wraps and runs again.

Each of up to eight lanes has three bits and a compare value:
- an enable bit;
- a select bit that picks between firing at once on the event (bypass) and firing when the counter matches the lane's delay;
- a chaining bit that also fires the lane when the previous lane reports conversion complete on `cc_in`.

Delay and interrupt-delay writes go to holding registers. They take effect only while the counter is idle, or at a counter restart once software has armed a load.

A small register port gives write access and combinational read access. Register map, by word address:

| Address | Content |
|---|---|
| 0 | control and status |
| 1 | modulus |
| 2 | interrupt delay |
| 3 | lane control word |
| 4+i | delay of lane i |

Top module: `pretrig_sched`

## Requirements
- R1: The lane control word at address 3 packs the chaining bits in 23:16, the select bits in 15:8 (1 = delay mode, 0 = bypass) and the lane enables in 7:0. Bits 31:24 always read as zero.
- R2: An enabled bypass lane pulses for exactly one cycle, in the cycle right after the edge on which the start event is seen. That cycle is called cycle E.
- R3: An enabled delay-mode lane with delay d, where d is at most the modulus, pulses once in cycle E+1+d.
- R4: With control bit 3 set, the start event is a control write with bit 4 set. With control bit 3 clear, the start event is a rising edge of `trig_in`, and an input held high gives only one event.
- R5: A lane whose enable bit is 0 never pulses, whatever its mode.
- R6: A lane with its chaining bit and enable bit set pulses once, one cycle after each rising edge of `cc_in` of the previous lane. Lane 0 follows the last lane. Chaining bits on lanes that are not a chain head may give odd behaviour, but the block never stalls.
- R7: With control bit 0 set, `irq_flag` rises in cycle E+1+D, where D is the interrupt delay. The flag reads back at control bit 8, and writing 1 to control bit 8 clears it.
- R8: Delay writes go to holding registers. A delay address reads the value in effect. The held value takes effect within one cycle while idle, or at a counter restart when control bit 2 (load armed) is set. That bit then clears.
- R9: The counter counts 0 to the modulus and then stops, with control bit 9 (busy) low. With control bit 1 set it wraps to 0 instead, so delay matches repeat every modulus+1 cycles.
- R10: A start event while counting restarts the counter at zero. A compare match that falls on the restart edge is dropped, so the old pass gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Hardware start input |
| cc_in | input | LANES | Conversion-complete per lane |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pretrig | output | LANES | Pre-trigger pulses |
| irq_flag | output | 1 | Interrupt flag |

## Verification
A restart and a pending delay compare can land on the same clock edge. The bench provokes this by issuing a software start exactly in the cycle before lane 1's compare would show. The scoreboard drops the old pass's expected pulses from the restart cycle onward. It then requires only the bypass pulse in that cycle, and the lane 1 pulse a full delay later. A loaded delay value is confirmed in the same sequence, by reading it back before and after the armed restart.

// File: rtl/pretrig_sched.sv
module pretrig_sched #(
  parameter int LANES  = 8,
  parameter int CW     = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic [LANES-1:0]  cc_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [LANES-1:0]  pretrig,
  output logic              irq_flag
);

  logic irq_en, wrap, load_ok, sw_sel, running, trig_q;
  logic [CW-1:0] cnt, modv, idly_h, idly;
  logic [LANES-1:0] en, tos, bb, cc_q, hit, fire;
  logic [CW-1:0] dly_h [LANES];
  logic [CW-1:0] dly   [LANES];

  wire wr_ctrl = wr_en && addr == ADDR_W'(0);
  wire ev      = (sw_sel && wr_ctrl && wdata[4]) || (!sw_sel && trig_in && !trig_q);
  wire at_end  = running && cnt == modv;
  wire restart = ev || (at_end && wrap);
  wire load    = !running || (load_ok && restart);

  wire [LANES-1:0] cc_rise = cc_in & ~cc_q;
  wire [LANES-1:0] chain   = {cc_rise[LANES-2:0], cc_rise[LANES-1]};

  always_comb
    for (int i = 0; i < LANES; i++)
      hit[i] = running && !ev && tos[i] && cnt == dly[i];

  assign fire = en & ((ev ? ~tos : '0) | hit | (bb & chain));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; running <= 1'b0; trig_q <= 1'b0; cc_q <= '0;
      pretrig <= '0; irq_flag <= 1'b0;
    end else begin
      trig_q  <= trig_in;
      cc_q    <= cc_in;
      pretrig <= fire;
      if (ev) begin
        cnt <= '0; running <= 1'b1;
      end else if (at_end) begin
        if (wrap) cnt <= '0;
        else running <= 1'b0;
      end else if (running) cnt <= cnt + 1'b1;
      if (running && !ev && irq_en && cnt == idly) irq_flag <= 1'b1;
      else if (wr_ctrl && wdata[8]) irq_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 1'b0; wrap <= 1'b0; load_ok <= 1'b0; sw_sel <= 1'b0;
      modv <= '0; idly_h <= '0; idly <= '0; en <= '0; tos <= '0; bb <= '0;
      for (int i = 0; i < LANES; i++) begin dly_h[i] <= '0; dly[i] <= '0; end
    end else begin
      if (load) begin
        idly <= idly_h;
        for (int i = 0; i < LANES; i++) dly[i] <= dly_h[i];
      end
      if (wr_ctrl) begin
        irq_en <= wdata[0]; wrap <= wdata[1]; sw_sel <= wdata[3];
        load_ok <= wdata[2] || (load_ok && !restart);
      end else if (restart) load_ok <= 1'b0;
      if (wr_en && addr == ADDR_W'(1)) modv <= wdata[CW-1:0];
      if (wr_en && addr == ADDR_W'(2)) idly_h <= wdata[CW-1:0];
      if (wr_en && addr == ADDR_W'(3)) begin
        en <= wdata[0 +: LANES]; tos <= wdata[8 +: LANES]; bb <= wdata[16 +: LANES];
      end
      for (int i = 0; i < LANES; i++)
        if (wr_en && addr == ADDR_W'(4 + i)) dly_h[i] <= wdata[CW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(0): rdata[9:0] = {running, irq_flag, 4'b0, sw_sel, load_ok, wrap, irq_en};
      ADDR_W'(1): rdata[CW-1:0] = modv;
      ADDR_W'(2): rdata[CW-1:0] = idly;
      ADDR_W'(3): begin
        rdata[0 +: LANES] = en; rdata[8 +: LANES] = tos; rdata[16 +: LANES] = bb;
      end
      default:
        for (int i = 0; i < LANES; i++)
          if (addr == ADDR_W'(4 + i)) rdata[CW-1:0] = dly[i];
    endcase
  end

  p_bypass_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> ((pretrig & $past(en & ~tos)) == $past(en & ~tos)));

  p_enable_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pretrig & ~$past(en)) == '0);

  p_irq_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !ev && irq_en && cnt == idly) |=> irq_flag);

  p_stop_at_mod_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !wrap && !ev) |=> !running);

  p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> (running && cnt == '0));

  p_hold_effective_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !restart) |=> $stable(idly));

endmodule

// File: tb/pretrig_sched_tb_top.sv
module pretrig_sched_tb_top;
  logic clk = 0, rst_n = 0, trig_in = 0, wr_en = 0;
  logic [7:0] cc_in = '0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0] pretrig;
  logic irq_flag;

  pretrig_sched dut_i (.clk, .rst_n, .trig_in, .cc_in, .wr_en, .addr, .wdata,
                       .rdata, .pretrig, .irq_flag);

  always #5 clk = ~clk;

  typedef struct { int c; logic [7:0] m; } exp_t;
  exp_t q[$];
  int cyc = 0, nchk = 0, nfail = 0, last_e = 0, m_mod = 0;
  logic [7:0] m_en = '0, m_tos = '0;
  int m_dly [8];
  logic [31:0] ctrl_base = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (q.size() > 0 && q[0].c == cyc) begin
      check("R2/R3/R6 pulse", {24'b0, pretrig}, {24'b0, q[0].m});
      void'(q.pop_front());
    end else if (pretrig != '0)
      check("R5/R10 unexpected pulse", {24'b0, pretrig}, 32'b0);
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = 4'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rdchk(string tag, int a, logic [31:0] exp);
    @(negedge clk); addr = 4'(a); #1;
    check(tag, rdata, exp);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic push_pass(int e);
    while (q.size() > 0 && q[q.size()-1].c >= e) void'(q.pop_back());
    for (int t = 0; t < 64; t++) begin
      logic [7:0] m = (t == 0) ? (m_en & ~m_tos) : 8'b0;
      for (int i = 0; i < 8; i++)
        if (m_en[i] && m_tos[i] && m_dly[i] <= m_mod && m_dly[i] + 1 == t) m[i] = 1'b1;
      if (m != '0) q.push_back('{c: e + t, m: m});
    end
  endtask

  task automatic sw_trig();
    @(negedge clk); wr_en = 1; addr = 0; wdata = ctrl_base | 32'h10;
    last_e = cyc + 1; push_pass(last_e);
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_dly[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    check("R1 reset pretrig", {24'b0, pretrig}, 32'b0);
    check("R7 reset irq", {31'b0, irq_flag}, 32'b0);
    rdchk("R1 reset lane word", 3, 32'h0);
    // R1: reserved byte reads zero
    wr(3, 32'hFFFF_FFFF);
    rdchk("R1 lane word layout", 3, 32'h00FF_FFFF);
    // R2 R3 R5: mixed lanes, software start (R4)
    m_mod = 20; wr(1, 20);
    m_dly[1] = 3; m_dly[2] = 5; m_dly[3] = 0; m_dly[4] = 2;
    for (int i = 1; i < 5; i++) wr(4 + i, 32'(m_dly[i]));
    m_en = 8'h0F; m_tos = 8'h1E; wr(3, 32'h0000_1E0F);
    ctrl_base = 32'h8; wr(0, ctrl_base);
    repeat (2) @(negedge clk);
    sw_trig();
    repeat (30) @(negedge clk);
    check("R3 all pass pulses seen", q.size(), 0);
    // R4: hardware edge held high gives one event
    ctrl_base = 32'h0; wr(0, 0);
    @(negedge clk); trig_in = 1; last_e = cyc + 1; push_pass(last_e);
    repeat (10) @(negedge clk); trig_in = 0;
    repeat (30) @(negedge clk);
    check("R4 hw pass pulses seen", q.size(), 0);
    // R7: interrupt delay and clear
    wr(2, 7); ctrl_base = 32'h9; wr(0, ctrl_base);
    repeat (2) @(negedge clk);
    sw_trig();
    wait_to(last_e + 7);
    check("R7 irq not early", {31'b0, irq_flag}, 32'b0);
    @(negedge clk);
    check("R7 irq at E+1+D", {31'b0, irq_flag}, 32'b1);
    rdchk("R7 irq readback", 0, 32'h309);
    repeat (25) @(negedge clk);
    wr(0, 32'h109);
    check("R7 irq cleared", {31'b0, irq_flag}, 32'b0);
    // R8: double buffering with armed load at restart
    ctrl_base = 32'h8; wr(0, ctrl_base);
    m_mod = 200; wr(1, 200);
    sw_trig();
    repeat (12) @(negedge clk);
    wr(5, 9);
    rdchk("R8 effective kept while running", 5, 32'd3);
    wr(0, ctrl_base | 32'h4);
    m_dly[1] = 9; sw_trig();
    rdchk("R8 loaded at restart", 5, 32'd9);
    rdchk("R8 load bit cleared", 0, 32'h208);
    // R10: restart on the edge of lane 1's compare
    wait_to(last_e + 9);
    sw_trig();
    repeat (215) @(negedge clk);
    check("R10 restart pulses seen", q.size(), 0);
    // R6: chaining from lane 4 to lane 5; lane 3 not chained
    m_mod = 20; wr(1, 20);
    m_en = 8'h2F; wr(3, 32'h0020_1E2F);
    @(negedge clk); cc_in = 8'h10; q.push_back('{c: cyc + 1, m: 8'h20});
    repeat (3) @(negedge clk); cc_in = 8'h00;
    @(negedge clk); cc_in = 8'h04;
    repeat (3) @(negedge clk); cc_in = 8'h00;
    repeat (3) @(negedge clk);
    check("R6 chain pulse seen", q.size(), 0);
    // R9: wrap mode then stop
    m_mod = 4; wr(1, 4); wr(5, 1); wr(3, 32'h0000_0202);
    ctrl_base = 32'hA; wr(0, ctrl_base);
    repeat (2) @(negedge clk);
    m_en = 8'h00; sw_trig(); m_en = 8'h02;
    q.push_back('{c: last_e + 2, m: 8'h02});
    q.push_back('{c: last_e + 7, m: 8'h02});
    q.push_back('{c: last_e + 12, m: 8'h02});
    wait_to(last_e + 9);
    ctrl_base = 32'h8; wr(0, ctrl_base);
    repeat (20) @(negedge clk);
    check("R9 wrap pulses seen", q.size(), 0);
    rdchk("R9 stopped after wrap off", 0, 32'h008);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R10: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule